// File: doc/BRIEF.md
# Glitch-free dual clock output gate

This block takes one reference clock and passes it to two outputs, each gated on its own. An output runs only while two conditions agree: its external enable pin is high and its enable bit from a register is high. Pulling either one low stops that output. The other output keeps toggling, and the shared clock path is untouched.

Starting and stopping are synchronous to the reference clock, so an output never carries a shortened or stretched pulse. The combined enable for each output passes through a synchronizer clocked by the reference clock. The synchronized value is then captured on the falling clock edge, so the gate opens or closes only while the clock is low. A stopped output rests at logic 0. A per-output status bit reports whether the gate is currently open.

After an asynchronous reset both outputs are held low and both status bits read 0. An output starts only once reset has been released and its synchronized enable is high.

Top module: `dual_clkgate`

## Requirements
- R1: An output runs (`clk_out[i]` equals `ref_clk` during every high phase) only when both `en_pin[i]` and `en_reg[i]` are 1. Bit i of each vector belongs to output i.
- R2: If `en_pin[i]` or `en_reg[i]` is 0 at a rising edge of `ref_clk`, output i is low throughout the high phase that follows the next-but-one rising edge.
- R3: When an output is stopped, its final level is low. Every high phase of `ref_clk` in which the output is high is a complete phase, with no truncated pulse.
- R4: An output that restarts produces only full-width pulses. Its first pulse starts on a rising edge of `ref_clk`.
- R5: Restart latency is exactly two reference cycles, which lies inside the allowed window of two to six cycles. If the combined enable is 1 at rising edge k, then the first output pulse begins at rising edge k+2.
- R6: The two outputs are independent. Stopping or starting one output does not change the other.
- R7: While `rst_n` is 0, both `clk_out` bits and both `running` bits are 0. The same holds in the first two cycles after reset is released.
- R8: `running[i]` is 1 exactly when the gate of output i is open. It changes only in the low phase of `ref_clk` and is the level seen on `clk_out[i]` during the following high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock to be gated |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_pin | input | 2 | Raw enable pins, asynchronous, active high, bit i for output i |
| en_reg | input | 2 | Register enable bits, active high, bit i for output i |
| clk_out | output | 2 | Gated clock outputs, low when stopped |
| running | output | 2 | Gate-open status per output |

## Verification
On every cycle, the assertions check four things: the two-cycle relation between a combined enable and the status bit, for both starting and stopping; that a stopped output is low in the high phase; and that reset holds everything low. Only the bench's scenarios can show the rest. These are whole-pulse behaviour across long enable patterns, isolated one-cycle enable pulses, the independence of one output while the other toggles, and the recovery after a reset in mid-run. The bench checks them by sampling each output in both clock phases against a delayed queue of expected gate states.

// File: rtl/dcg_pkg.sv
package dcg_pkg;
  // Number of reference-clock rising edges between a combined enable being
  // sampled and the gate acting on it; the falling-edge gate stage adds no
  // full cycle to the latency seen at the outputs.
  function automatic int restart_cycles(input int sync_stages);
    return sync_stages;
  endfunction
endpackage

// File: rtl/en_sync.sv
module en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gate_cell.sv
module gate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic en_sync,
  output logic gated_clk,
  output logic gate_open
);
  logic gate_q;

  // Updated while the clock falls, so the gate is steady across each high phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= en_sync;
  end

  assign gated_clk = clk & gate_q;
  assign gate_open = gate_q;
endmodule

// File: rtl/dual_clkgate.sv
module dual_clkgate #(
  parameter int NUM_OUT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic [NUM_OUT-1:0] en_pin,
  input  logic [NUM_OUT-1:0] en_reg,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] running
);
  import dcg_pkg::*;

  localparam int LAT = restart_cycles(SYNC_STAGES);

  logic [NUM_OUT-1:0] en_comb;
  logic [NUM_OUT-1:0] en_synced;

  assign en_comb = en_pin & en_reg;

  generate
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      en_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .d_async (en_comb[i]),
        .q_sync  (en_synced[i])
      );

      gate_cell u_gate (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .en_sync   (en_synced[i]),
        .gated_clk (clk_out[i]),
        .gate_open (running[i])
      );

      if (LAT == 2) begin : g_chk
        // R5: enable held over two edges opens the gate within two cycles
        assert_restart_latency_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
          en_comb[i] ##1 en_comb[i] |=> running[i]);
        // R2: a low combined enable closes the gate two cycles later
        assert_stop_latency_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
          !en_comb[i] |=> ##1 !running[i]);
      end

      // R3: a stopped output stays low through the high phase
      assert_stopped_low_R3: assert property (@(negedge ref_clk) disable iff (!rst_n)
        !running[i] |-> !clk_out[i]);
      // R7: reset holds output and status low
      assert_reset_low_R7: assert property (@(posedge ref_clk)
        !rst_n |-> (!clk_out[i] && !running[i]));
    end
  endgenerate
endmodule

// File: tb/dual_clkgate_test.sv
module dual_clkgate_test;
  logic       ref_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic [1:0] en_pin  = 2'b00;
  logic [1:0] en_reg  = 2'b00;
  logic [1:0] clk_out;
  logic [1:0] running;

  int checks   = 0;
  int failures = 0;
  bit mon_on   = 1'b0;
  bit done     = 1'b0;

  typedef struct packed { logic [1:0] exp; logic [7:0] tag; } item_t;
  item_t q[$];

  dual_clkgate uut (
    .ref_clk (ref_clk), .rst_n (rst_n), .en_pin (en_pin), .en_reg (en_reg),
    .clk_out (clk_out), .running (running)
  );

  always #4 ref_clk = ~ref_clk;

  task automatic chk(input bit ok, input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: one call per cycle, applied in the low phase before a rising edge.
  task automatic step(input logic [1:0] pin, input logic [1:0] rg, input logic [7:0] tag);
    item_t it;
    @(negedge ref_clk);
    en_pin = pin;
    en_reg = rg;
    it.exp = pin & rg;
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: the gate state applied at edge k is seen in the high phase after edge k+2 (R5).
  always @(posedge ref_clk) begin
    #2;
    if (mon_on && q.size() >= 3) begin
      item_t it;
      it = q.pop_front();
      chk(running == it.exp, "R8/R5 running", running, it.exp);
      chk(clk_out == it.exp, "R1/R2/R6 clk_out high phase", clk_out, it.exp);
    end
  end

  // Low phase: every output is low whatever its state (R3, R4: no stretched pulse).
  always @(negedge ref_clk) begin
    #2;
    if (mon_on) chk(clk_out == 2'b00, "R3/R4 clk_out low phase", clk_out, 2'b00);
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    repeat (3) @(posedge ref_clk);
    #2;
    chk(clk_out == 2'b00, "R7 reset clk_out", clk_out, 2'b00);
    chk(running == 2'b00, "R7 reset running", running, 2'b00);
    // Enables high during reset must not start the outputs (R7).
    en_pin = 2'b11; en_reg = 2'b11;
    @(posedge ref_clk); #2;
    chk(running == 2'b00, "R7 reset with enables high", running, 2'b00);
    @(negedge ref_clk);
    en_pin = 2'b00; en_reg = 2'b00;
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R1: both run when pin and register agree
    repeat (8) step(2'b11, 2'b11, 8'd1);
    // R2: pin 0 low stops output 0 only (R6)
    repeat (6) step(2'b10, 2'b11, 8'd2);
    // R2: register bit 1 low stops output 1, output 0 restarts (R4, R6)
    repeat (6) step(2'b11, 2'b01, 8'd3);
    // both stopped
    repeat (5) step(2'b11, 2'b00, 8'd4);
    // R5: isolated one-cycle enable gives exactly one full pulse
    step(2'b01, 2'b11, 8'd5);
    repeat (4) step(2'b00, 2'b11, 8'd5);
    step(2'b10, 2'b10, 8'd5);
    repeat (4) step(2'b00, 2'b00, 8'd5);
    // pseudo-random enable patterns on both outputs
    lfsr = 8'hA5;
    for (int n = 0; n < 120; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[1:0], lfsr[3:2] | lfsr[5:4], 8'd6);
    end
    repeat (6) step(2'b11, 2'b11, 8'd7);
    repeat (2) @(posedge ref_clk);
    #3;
    mon_on = 1'b0;
    // R7: reset in mid-run stops both outputs at once
    #1;
    rst_n = 1'b0;
    #1;
    chk(running == 2'b00, "R7 mid-run reset running", running, 2'b00);
    @(negedge ref_clk); #2;
    chk(clk_out == 2'b00, "R7 mid-run reset clk_out", clk_out, 2'b00);
    @(posedge ref_clk); #2;
    chk(clk_out == 2'b00, "R7 reset high phase", clk_out, 2'b00);
    // release with enables high: first two cycles stay low, then both run (R5, R7)
    @(negedge ref_clk);
    rst_n = 1'b1;
    @(posedge ref_clk); #2;
    chk(clk_out == 2'b00, "R7 first cycle after release", clk_out, 2'b00);
    @(posedge ref_clk); #2;
    chk(clk_out == 2'b00, "R5 second cycle after release", clk_out, 2'b00);
    @(posedge ref_clk); #2;
    chk(clk_out == 2'b11, "R5 running after two cycles", clk_out, 2'b11);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule